// File: doc/BRIEF.md
# Complementary PWM Generator with Dead Band

This block drives the two gate inputs of a synchronous converter stage: a high-side switch and a low-side (synchronous rectifier) switch. A free-running counter of `CNT_W` bits sets the switching period. The high side is asked for while the count is below the active duty value, and the low side is asked for during the rest of the period, so the two gates run in opposite phase.

Each gate turns on only after its demand has held for `DEAD` clock cycles. It turns off in the cycle after its demand drops. Together these rules give a guaranteed interval where both gates are low at every hand-over. They also shorten each on-time by `DEAD` cycles, and they swallow any demand pulse of `DEAD` cycles or less. A new duty word is staged on a load strobe and takes effect only at the start of the next period, so a period never changes shape part way through.

The duty word is sampled continuously while reset is held. Switching starts from that value as soon as reset is released.

Top module: `cpwm_deadband`

## Requirements
- R1: With default parameters (period 256 cycles, `DEAD` = 4) and a duty value D held steady, every period has exactly max(D-4, 0) high-side cycles and max(256-D-4, 0) low-side cycles, except at D = 0. Each high-side pulse starts `DEAD` cycles into the period.
- R2: While `rst_ni` is low, both gate outputs are low after the first clock edge. When reset is released, the first period uses the `duty_i` value that was present during reset. Its high-side pulse starts `DEAD` cycles into that period.
- R3: `hi_gate_o` and `lo_gate_o` are never high in the same cycle.
- R4: Before either output rises, both outputs have been low for at least `DEAD` consecutive cycles.
- R5: At duty 0 the high side never turns on. The low side stays high for the whole of every period once the period before it also had duty 0.
- R6: At duty 255 the low side is never high, and the high side is high for 255-`DEAD` cycles per period.
- R7: A demand that lasts `DEAD` cycles or fewer makes no pulse at all. At the defaults, duty 1 to 4 gives no high-side pulse and duty 252 to 255 gives no low-side pulse. Duty 5 gives a 1-cycle high pulse, and duty 251 gives a 1-cycle low pulse.
- R8: A strobe on `load_i` captures `duty_i`. The period in progress keeps the old duty. The captured value governs the next period. A strobe in the last cycle of a period governs the very next period.
- R9: Changes on `duty_i` without a strobe on `load_i` have no effect on the outputs after reset.
- R10: The active duty value changes only in the cycle where the counter wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| duty_i | input | CNT_W | Requested duty, 0 = high side always off |
| load_i | input | 1 | Strobe that captures `duty_i` for the next period |
| hi_gate_o | output | 1 | High-side gate drive |
| lo_gate_o | output | 1 | Low-side gate drive |

## Verification
The bench targets the duty extremes 0 and 255, and the runt boundaries on both sides of `DEAD` (duty 1, 4, 5, 251 and 252). A design that emits short pulses instead of suppressing them, or that lets the low side rise at duty 255, would show nonzero cycle counts where zero is expected. It also loads duty mid-period and in the last cycle of a period. A design that applies duty immediately would distort the current period, and one that misses a strobe at the wrap point would lag a full period. A missing or too-short dead band shows up as an overlap, or as a rising edge that follows too few idle cycles.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   // Side index used by the per-gate generate loop
   typedef enum logic [0:0] {
      SIDE_HI = 1'b0,
      SIDE_LO = 1'b1
   } side_e;

   localparam int unsigned NUM_SIDES = 2;

   // Width needed to count 0..n
   function automatic int unsigned run_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/cpwm_period_ctr.sv
module cpwm_period_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             load_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] duty_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pend_q;
   logic [CNT_W-1:0] act_q;
   logic             wrap;

   assign wrap = (cnt_q == CNT_MAX);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         pend_q <= duty_i;
         act_q  <= duty_i;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (load_i) begin
            pend_q <= duty_i;
         end
         if (wrap) begin
            act_q <= load_i ? duty_i : pend_q;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign duty_o = act_q;
endmodule

// File: rtl/cpwm_dead_gate.sv
module cpwm_dead_gate #(
   parameter int unsigned DEAD  = 4,
   parameter int unsigned RUN_W = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic gate_o
);
   localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(DEAD);

   logic [RUN_W-1:0] run_q;
   logic             gate_q;

   // run_q counts how long the demand has held, saturating at DEAD
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q  <= '0;
         gate_q <= 1'b0;
      end else begin
         if (!req_i) begin
            run_q <= '0;
         end else if (run_q != RUN_SAT) begin
            run_q <= run_q + 1'b1;
         end
         gate_q <= req_i && (run_q == RUN_SAT);
      end
   end

   assign gate_o = gate_q;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DEAD  = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             load_i,
   output logic             hi_gate_o,
   output logic             lo_gate_o
);
   import cpwm_pkg::*;

   localparam int unsigned RUN_W = run_width(DEAD);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("cpwm_deadband: CNT_W must be in 2..16");
      end
      if (DEAD < 1 || DEAD >= (1 << (CNT_W - 1))) begin : g_bad_dead
         $error("cpwm_deadband: DEAD must be at least 1 and below half a period");
      end
   endgenerate

   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     duty_act;
   logic [NUM_SIDES-1:0] req_vec;
   logic [NUM_SIDES-1:0] gate_vec;

   cpwm_period_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .duty_i (duty_i),
      .load_i (load_i),
      .cnt_o  (cnt_q),
      .duty_o (duty_act)
   );

   // Opposite-phase demands: high side first, low side for the remainder
   assign req_vec[SIDE_HI] = (cnt_q < duty_act);
   assign req_vec[SIDE_LO] = !(cnt_q < duty_act);

   for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
      cpwm_dead_gate #(
         .DEAD  (DEAD),
         .RUN_W (RUN_W)
      ) u_gate (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .req_i  (req_vec[g]),
         .gate_o (gate_vec[g])
      );
   end

   assign hi_gate_o = gate_vec[SIDE_HI];
   assign lo_gate_o = gate_vec[SIDE_LO];
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DEAD  = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             hi_i,
   input logic             lo_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [CNT_W-1:0] duty_i
);
   localparam int unsigned     GAP_W   = $clog2(DEAD + 1) + 1;
   localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(DEAD);
   localparam logic [CNT_W-1:0] DUTY_FULL = '1;

   logic [GAP_W-1:0] gap_q;

   // Consecutive cycles with both gates low, saturating at DEAD
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gap_q <= GAP_SAT;
      end else if (hi_i || lo_i) begin
         gap_q <= '0;
      end else if (gap_q != GAP_SAT) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R3
   a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hi_i && lo_i));

   // R4
   a_r4_dead_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(hi_i) || $rose(lo_i)) |-> (gap_q == GAP_SAT));

   // R2
   a_r2_reset_low: assert property (@(posedge clk_i)
      !rst_ni |=> (!hi_i && !lo_i));

   // R5
   a_r5_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_i == '0) |-> !hi_i);

   // R6
   a_r6_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((duty_i == DUTY_FULL) && (cnt_i != '0)) |-> !lo_i);

   // R10
   a_r10_duty_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && (cnt_i != '0)) |-> $stable(duty_i));
endmodule

bind cpwm_deadband cpwm_deadband_chk #(
   .CNT_W (CNT_W),
   .DEAD  (DEAD)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .hi_i   (hi_gate_o),
   .lo_i   (lo_gate_o),
   .cnt_i  (cnt_q),
   .duty_i (duty_act)
);

// File: tb/cpwm_deadband_bench.sv
module cpwm_deadband_bench;
   localparam int T   = 4;
   localparam int PER = 256;
   localparam int NV  = 10;
   // {duty, expected high cycles, expected low cycles} at DEAD = 4
   localparam logic [25:0] VEC [NV] = '{
      {8'd128, 9'd124, 9'd124},
      {8'd0,   9'd0,   9'd256},
      {8'd255, 9'd251, 9'd0},
      {8'd1,   9'd0,   9'd251},
      {8'd4,   9'd0,   9'd248},
      {8'd5,   9'd1,   9'd247},
      {8'd252, 9'd248, 9'd0},
      {8'd251, 9'd247, 9'd1},
      {8'd64,  9'd60,  9'd188},
      {8'd200, 9'd196, 9'd52}
   };

   logic       clk_i = 1'b0;
   logic       rst_ni;
   logic [7:0] duty_i;
   logic       load_i;
   logic       hi_gate_o;
   logic       lo_gate_o;

   int errors = 0;
   int checks = 0;
   int ovl = 0;
   int gapbad = 0;
   int idle = 1000;
   logic phi = 1'b0;
   logic plo = 1'b0;

   always #2 clk_i = ~clk_i;

   cpwm_deadband u_cpwm_deadband (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .duty_i    (duty_i),
      .load_i    (load_i),
      .hi_gate_o (hi_gate_o),
      .lo_gate_o (lo_gate_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk_i);
      #1;
      if (hi_gate_o && lo_gate_o) ovl++;
      if (((hi_gate_o && !phi) || (lo_gate_o && !plo)) && idle < T) gapbad++;
      idle = (hi_gate_o || lo_gate_o) ? 0 : idle + 1;
      phi = hi_gate_o;
      plo = lo_gate_o;
   endtask

   // One full period, output positions c = 0..255; optional strobe at position load_at
   task automatic run_window(input int load_at, input logic [7:0] ldv,
                             output int hc, output int lc, output int fh);
      hc = 0;
      lc = 0;
      fh = -1;
      for (int i = 0; i < PER; i++) begin
         step();
         if (hi_gate_o) begin
            if (fh < 0) fh = i;
            hc++;
         end
         if (lo_gate_o) lc++;
         load_i = (i == load_at);
         if (i == load_at) duty_i = ldv;
      end
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int hc, lc, fh;
      rst_ni = 1'b0;
      duty_i = 8'd128;
      load_i = 1'b0;
      repeat (3) @(posedge clk_i);
      #1;
      chk(!hi_gate_o && !lo_gate_o, "R2 reset low", {hi_gate_o, lo_gate_o}, 0);
      rst_ni = 1'b1;

      // First period after reset uses the duty seen during reset (R2, R1)
      run_window(-1, 8'd0, hc, lc, fh);
      chk(hc == 124, "R2 first period high", hc, 124);
      chk(lc == 124, "R2 first period low", lc, 124);
      chk(fh == T, "R2 first high position", fh, T);

      // Vector table walk (R1, R5, R6, R7)
      for (int v = 0; v < NV; v++) begin
         logic [7:0] d;
         int eh, el;
         d  = VEC[v][25:18];
         eh = int'(VEC[v][17:9]);
         el = int'(VEC[v][8:0]);
         run_window(100, d, hc, lc, fh);
         run_window(-1, 8'd0, hc, lc, fh);
         run_window(-1, 8'd0, hc, lc, fh);
         chk(hc == eh, $sformatf("R1 R5 R6 R7 high count duty=%0d", d), hc, eh);
         chk(lc == el, $sformatf("R1 R5 R6 R7 low count duty=%0d", d), lc, el);
         if (eh > 0) chk(fh == T, $sformatf("R1 high start duty=%0d", d), fh, T);
      end

      // R8: mid-period strobe leaves the current period alone
      run_window(100, 8'd64, hc, lc, fh);
      chk(hc == 196, "R8 current period keeps old duty", hc, 196);
      run_window(-1, 8'd0, hc, lc, fh);
      chk(hc == 60, "R8 next period uses new duty", hc, 60);
      // R8: strobe in the last cycle of a period
      run_window(254, 8'd128, hc, lc, fh);
      chk(hc == 60, "R8 last-cycle strobe period", hc, 60);
      run_window(-1, 8'd0, hc, lc, fh);
      chk(hc == 124, "R8 last-cycle strobe applies next", hc, 124);

      // R9: duty input without strobe is ignored
      duty_i = 8'd10;
      run_window(-1, 8'd0, hc, lc, fh);
      run_window(-1, 8'd0, hc, lc, fh);
      chk(hc == 124, "R9 no strobe high count", hc, 124);
      chk(lc == 124, "R9 no strobe low count", lc, 124);

      chk(ovl == 0, "R3 overlap cycles", ovl, 0);
      chk(gapbad == 0, "R4 short dead band edges", gapbad, 0);

      // R2: reset during operation forces both low
      rst_ni = 1'b0;
      step();
      chk(!hi_gate_o && !lo_gate_o, "R2 reset mid-run", {hi_gate_o, lo_gate_o}, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule